// File: doc/BRIEF.md
# Write CRC Status Token Receiver

This block watches the DAT0 line of a card bus on the host side. After the host has sent a write data block and pulsed `blk_sent`, the block waits for the card's CRC status token, shifts in its three status bits, checks the end bit, and then times the busy period during which the card holds DAT0 low while it programs. It raises `tok_ok` for a positive token and `busy_done` when the card releases DAT0.

A second, independent watcher times the wait for a read start bit. `rd_wait` arms it, and DAT0 sampled low ends the wait. Both watchers count only card clocks, which are the cycles where `card_ce` is high, against the programmable limit `tmo_limit`. The three error flags (data timeout, data CRC, data end bit) stay set until `err_clr` is pulsed. They are also presented as a 16-bit error code word.

Top module: `crc_status_rx`

## Requirements
- R1: After reset, `tok_ok`, `busy_done`, all three error flags and `err_code` are 0.
- R2: After `blk_sent`, the token is start bit 0, then three status bits MSB first, then end bit 1, each sampled on a card clock. For status 010 with end bit 1, `tok_ok` is high for one clock after the end-bit card clock, and no error flag is set.
- R3: A status value other than 010 sets the data CRC flag and gives no `tok_ok`.
- R4: A 0 sampled at the end-bit position sets the data end-bit flag, whatever the status value.
- R5: If no start bit has been seen after `tmo_limit` card clocks of waiting for the token, both the data timeout and data CRC flags are set on the `tmo_limit`-th card clock and not before.
- R6: After the end bit, `busy_done` pulses for one clock after the first card clock where DAT0 is sampled high.
- R7: If DAT0 is sampled low on `tmo_limit` card clocks after the end bit, the data timeout flag is set on the last of them and `busy_done` does not fire.
- R8: After `rd_wait`, DAT0 sampled low within `tmo_limit` card clocks ends the wait with no error. `tmo_limit` card clocks with DAT0 high set the data timeout flag.
- R9: Cycles with `card_ce` low neither sample DAT0 nor advance any timeout count.
- R10: The error flags stay set until `err_clr`. If a flag is set in the same cycle as `err_clr`, the new setting wins.
- R11: `err_code` carries data timeout in bit 4 (0x0010), data CRC in bit 5 (0x0020) and data end bit in bit 6 (0x0040). All other bits are 0.
- R12: A new `blk_sent` or `rd_wait` restarts the corresponding timeout count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_ce | input | 1 | Card clock enable; DAT0 is sampled when high |
| dat0 | input | 1 | DAT0 line level |
| blk_sent | input | 1 | Strobe: a write block has been sent, await token |
| rd_wait | input | 1 | Strobe: arm the read start-bit timeout |
| err_clr | input | 1 | Strobe: clear the sticky error flags |
| tmo_limit | input | CNT_W | Timeout limit in card clocks |
| tok_ok | output | 1 | One-clock pulse for a positive status token |
| busy_done | output | 1 | One-clock pulse when card busy ends |
| err_dto | output | 1 | Sticky data timeout flag |
| err_dcrc | output | 1 | Sticky data CRC flag |
| err_dend | output | 1 | Sticky data end-bit flag |
| err_code | output | CODE_W | Error flags in code-word form |

## Verification
The write watcher and the read watcher share DAT0 and the error register, so both can set the data timeout flag in the same cycle. A clear strobe can also land on the cycle where an error is set. The bench arms `blk_sent` and `rd_wait` in one cycle and holds DAT0 high, so both limits expire on the same card clock. It checks that timeout and CRC are both set on exactly that clock and on none before it. It also pulses `err_clr` on the card clock where a read timeout expires, and expects the new timeout flag to survive while an older end-bit flag is cleared.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned ERR_DTO_POS = 4;
  localparam int unsigned ERR_CRC_POS = 5;
  localparam int unsigned ERR_END_POS = 6;
  localparam int unsigned N_ERR       = 3;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_TOKWAIT,
    WS_TOKBITS,
    WS_TOKEND,
    WS_BUSY
  } wstate_e;

  typedef struct packed {
    logic endb;
    logic crc;
    logic dto;
  } err_set_t;
endpackage

// File: rtl/dsr_timeout_ctr.sv
module dsr_timeout_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   seen;

  // seen = number of card clocks including the current one
  always_comb begin
    seen   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    expire = (seen >= {1'b0, limit});
    cnt_d  = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dsr_wr_fsm.sv
module dsr_wr_fsm
  import dsr_pkg::*;
#(
  parameter int unsigned          CNT_W     = 16,
  parameter int unsigned          STAT_BITS = 3,
  parameter logic [STAT_BITS-1:0] GOOD_STAT = 3'b010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_ce,
  input  logic             dat0,
  input  logic             blk_sent,
  input  logic [CNT_W-1:0] tmo_limit,
  output logic             tok_ok,
  output logic             busy_done,
  output err_set_t         set_o
);
  localparam int unsigned BC_W = (STAT_BITS > 1) ? $clog2(STAT_BITS) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(STAT_BITS - 1);

  wstate_e              state_q, state_d;
  logic [STAT_BITS-1:0] sh_q, sh_d;
  logic [BC_W-1:0]      bc_q, bc_d;
  logic                 ok_q, ok_d, done_q, done_d;
  logic                 ctr_restart, ctr_run, ctr_exp;

  dsr_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctr_restart),
    .run     (ctr_run),
    .limit   (tmo_limit),
    .expire  (ctr_exp)
  );

  always_comb begin
    state_d     = state_q;
    sh_d        = sh_q;
    bc_d        = bc_q;
    ok_d        = 1'b0;
    done_d      = 1'b0;
    set_o       = '0;
    ctr_restart = 1'b0;
    ctr_run     = 1'b0;
    if (blk_sent) begin
      state_d     = WS_TOKWAIT;
      ctr_restart = 1'b1;
    end else if (card_ce) begin
      case (state_q)
        WS_TOKWAIT: begin
          if (!dat0) begin
            state_d = WS_TOKBITS;
            bc_d    = '0;
          end else begin
            ctr_run = 1'b1;
            if (ctr_exp) begin
              set_o.dto = 1'b1;
              set_o.crc = 1'b1;
              state_d   = WS_IDLE;
            end
          end
        end
        WS_TOKBITS: begin
          sh_d = {sh_q[STAT_BITS-2:0], dat0};
          bc_d = bc_q + {{(BC_W-1){1'b0}}, 1'b1};
          if (bc_q == BC_LAST) state_d = WS_TOKEND;
        end
        WS_TOKEND: begin
          ctr_restart = 1'b1;
          state_d     = WS_BUSY;
          ok_d        = (sh_q == GOOD_STAT) && dat0;
          set_o.crc   = (sh_q != GOOD_STAT);
          set_o.endb  = !dat0;
        end
        WS_BUSY: begin
          if (dat0) begin
            done_d  = 1'b1;
            state_d = WS_IDLE;
          end else begin
            ctr_run = 1'b1;
            if (ctr_exp) begin
              set_o.dto = 1'b1;
              state_d   = WS_IDLE;
            end
          end
        end
        default: state_d = WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      sh_q    <= '0;
      bc_q    <= '0;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bc_q    <= bc_d;
      ok_q    <= ok_d;
      done_q  <= done_d;
    end
  end

  assign tok_ok    = ok_q;
  assign busy_done = done_q;
endmodule

// File: rtl/dsr_rd_watch.sv
module dsr_rd_watch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_ce,
  input  logic             dat0,
  input  logic             rd_wait,
  input  logic [CNT_W-1:0] tmo_limit,
  output logic             set_dto
);
  logic act_q, act_d, run, exp_w;

  dsr_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rd_wait),
    .run     (run),
    .limit   (tmo_limit),
    .expire  (exp_w)
  );

  always_comb begin
    act_d   = act_q;
    run     = 1'b0;
    set_dto = 1'b0;
    if (rd_wait) begin
      act_d = 1'b1;
    end else if (card_ce && act_q) begin
      if (!dat0) begin
        act_d = 1'b0;
      end else begin
        run = 1'b1;
        if (exp_w) begin
          set_dto = 1'b1;
          act_d   = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end
endmodule

// File: rtl/dsr_err_flags.sv
module dsr_err_flags
  import dsr_pkg::*;
#(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  err_set_t          set_i,
  output err_set_t          flags,
  output logic [CODE_W-1:0] code
);
  logic [N_ERR-1:0] q, d, s;

  assign s = set_i;

  for (genvar i = 0; i < N_ERR; i++) begin : g_flag
    always_comb d[i] = (q[i] & ~clr) | s[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end

  assign flags = q;

  always_comb begin
    code              = '0;
    code[ERR_DTO_POS] = flags.dto;
    code[ERR_CRC_POS] = flags.crc;
    code[ERR_END_POS] = flags.endb;
  end
endmodule

// File: rtl/crc_status_rx.sv
module crc_status_rx
  import dsr_pkg::*;
#(
  parameter int unsigned          CNT_W     = 16,
  parameter int unsigned          STAT_BITS = 3,
  parameter logic [STAT_BITS-1:0] GOOD_STAT = 3'b010,
  parameter int unsigned          CODE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_ce,
  input  logic              dat0,
  input  logic              blk_sent,
  input  logic              rd_wait,
  input  logic              err_clr,
  input  logic [CNT_W-1:0]  tmo_limit,
  output logic              tok_ok,
  output logic              busy_done,
  output logic              err_dto,
  output logic              err_dcrc,
  output logic              err_dend,
  output logic [CODE_W-1:0] err_code
);
  err_set_t wr_set, all_set, flags;
  logic     rd_dto;

  dsr_wr_fsm #(
    .CNT_W(CNT_W), .STAT_BITS(STAT_BITS), .GOOD_STAT(GOOD_STAT)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_ce   (card_ce),
    .dat0      (dat0),
    .blk_sent  (blk_sent),
    .tmo_limit (tmo_limit),
    .tok_ok    (tok_ok),
    .busy_done (busy_done),
    .set_o     (wr_set)
  );

  dsr_rd_watch #(.CNT_W(CNT_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_ce   (card_ce),
    .dat0      (dat0),
    .rd_wait   (rd_wait),
    .tmo_limit (tmo_limit),
    .set_dto   (rd_dto)
  );

  always_comb begin
    all_set     = wr_set;
    all_set.dto = wr_set.dto | rd_dto;
  end

  dsr_err_flags #(.CODE_W(CODE_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (err_clr),
    .set_i (all_set),
    .flags (flags),
    .code  (err_code)
  );

  assign err_dto  = flags.dto;
  assign err_dcrc = flags.crc;
  assign err_dend = flags.endb;
endmodule

// File: rtl/crc_status_rx_chk.sv
module crc_status_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic card_ce,
  input logic err_clr,
  input logic tok_ok,
  input logic busy_done,
  input logic err_dto,
  input logic err_dcrc,
  input logic err_dend
);
  // R2: a positive token never coincides with a new CRC or end-bit error
  p_tok_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ok |-> (!$rose(err_dcrc) && !$rose(err_dend)));

  // R6: busy_done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> !busy_done);

  // R9: outputs only react to a card clock
  p_done_on_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |-> $past(card_ce));
  p_tok_on_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ok |-> $past(card_ce));

  // R4: end-bit error only appears after a card clock
  p_end_on_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_dend) |-> $past(card_ce));

  // R10: flags are sticky without a clear
  p_sticky_dto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_dto && !err_clr) |=> err_dto);
  p_sticky_crc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_dcrc && !err_clr) |=> err_dcrc);
  p_sticky_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_dend && !err_clr) |=> err_dend);
endmodule

bind crc_status_rx crc_status_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_ce   (card_ce),
  .err_clr   (err_clr),
  .tok_ok    (tok_ok),
  .busy_done (busy_done),
  .err_dto   (err_dto),
  .err_dcrc  (err_dcrc),
  .err_dend  (err_dend)
);

// File: tb/crc_status_rx_test.sv
`timescale 1ns/1ps
module crc_status_rx_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        card_ce, dat0, blk_sent, rd_wait, err_clr;
  logic [15:0] tmo_limit;
  logic        tok_ok, busy_done, err_dto, err_dcrc, err_dend;
  logic [15:0] err_code;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  crc_status_rx uut (
    .clk(clk), .rst_n(rst_n), .card_ce(card_ce), .dat0(dat0),
    .blk_sent(blk_sent), .rd_wait(rd_wait), .err_clr(err_clr),
    .tmo_limit(tmo_limit), .tok_ok(tok_ok), .busy_done(busy_done),
    .err_dto(err_dto), .err_dcrc(err_dcrc), .err_dend(err_dend),
    .err_code(err_code)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // one clock: drive at negedge, sample just after the posedge
  task automatic drv(input logic ce, input logic d, input logic b, input logic r, input logic c);
    @(negedge clk);
    card_ce = ce; dat0 = d; blk_sent = b; rd_wait = r; err_clr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(); drv(0, 1, 0, 0, 0); endtask
  task automatic clear(); drv(0, 1, 0, 0, 1); idle(); endtask

  // start bit, three status bits MSB first; end bit left to caller
  task automatic tok_head(input logic [2:0] st);
    drv(0, 1, 1, 0, 0);
    drv(1, 0, 0, 0, 0);
    for (int i = 2; i >= 0; i--) drv(1, st[i], 0, 0, 0);
  endtask

  task automatic t_reset();
    eq("R1 tok_ok", {15'b0, tok_ok}, 16'h0);
    eq("R1 busy_done", {15'b0, busy_done}, 16'h0);
    eq("R1 err_code", err_code, 16'h0000);
  endtask

  task automatic t_good();
    clear();
    tok_head(3'b010);
    drv(1, 1, 0, 0, 0);
    eq("R2 tok_ok on end bit", {15'b0, tok_ok}, 16'h1);
    eq("R2 no error", err_code, 16'h0000);
    drv(1, 0, 0, 0, 0);
    eq("R2 tok_ok one cycle", {15'b0, tok_ok}, 16'h0);
    drv(1, 0, 0, 0, 0);
    eq("R6 busy still low", {15'b0, busy_done}, 16'h0);
    drv(1, 1, 0, 0, 0);
    eq("R6 busy_done", {15'b0, busy_done}, 16'h1);
    idle();
    eq("R6 busy_done pulse ends", {15'b0, busy_done}, 16'h0);
  endtask

  task automatic t_bad_status();
    clear();
    tok_head(3'b011);
    drv(1, 1, 0, 0, 0);
    eq("R3 no tok_ok", {15'b0, tok_ok}, 16'h0);
    eq("R3 crc flag", {15'b0, err_dcrc}, 16'h1);
    eq("R11 code crc", err_code, 16'h0020);
    drv(1, 1, 0, 0, 0);
    idle();
  endtask

  task automatic t_end_bit();
    clear();
    tok_head(3'b010);
    drv(1, 0, 0, 0, 0);
    eq("R4 end flag", {15'b0, err_dend}, 16'h1);
    eq("R11 code end", err_code, 16'h0040);
    drv(1, 1, 0, 0, 0);
    idle();
  endtask

  task automatic t_tok_timeout();
    clear();
    drv(0, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    eq("R5 nothing before limit", err_code, 16'h0000);
    drv(1, 1, 0, 0, 0);
    eq("R5 timeout+crc", err_code, 16'h0030);
  endtask

  task automatic t_busy_timeout();
    clear();
    tok_head(3'b010);
    drv(1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) drv(1, 0, 0, 0, 0);
    eq("R7 no timeout yet", {15'b0, err_dto}, 16'h0);
    drv(1, 0, 0, 0, 0);
    eq("R7 busy timeout", {15'b0, err_dto}, 16'h1);
    eq("R7 no busy_done", {15'b0, busy_done}, 16'h0);
    drv(1, 1, 0, 0, 0);
    eq("R7 no late busy_done", {15'b0, busy_done}, 16'h0);
  endtask

  task automatic t_read();
    clear();
    drv(0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    drv(1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0);
    drv(1, 1, 0, 0, 0);
    eq("R8 start bit in time", err_code, 16'h0000);
    drv(0, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) drv(1, 1, 0, 0, 0);
    eq("R8 read timeout", err_code, 16'h0010);
  endtask

  task automatic t_ce_gaps();
    clear();
    drv(0, 1, 1, 0, 0);
    drv(1, 0, 0, 0, 0);
    drv(0, 1, 0, 0, 0);
    drv(1, 0, 0, 0, 0);
    drv(0, 1, 0, 0, 0);
    drv(1, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 0);
    drv(1, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0);
    eq("R9 token across gaps", {15'b0, tok_ok}, 16'h1);
    drv(1, 1, 0, 0, 0);
    drv(0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) drv(0, 1, 0, 0, 0);
    eq("R9 gaps do not count", err_code, 16'h0000);
    drv(1, 1, 0, 0, 0);
    eq("R9 count resumes", err_code, 16'h0010);
  endtask

  task automatic t_clear();
    clear();
    tok_head(3'b010);
    drv(1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) idle();
    eq("R10 flag holds", err_code, 16'h0040);
    drv(0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    drv(1, 1, 0, 0, 1);
    eq("R10 set wins over clear", err_code, 16'h0010);
    clear();
    eq("R10 clear", err_code, 16'h0000);
  endtask

  task automatic t_rearm();
    clear();
    drv(0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    drv(0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    eq("R12 read rearm restarts", err_code, 16'h0000);
    drv(1, 1, 0, 0, 0);
    eq("R12 read expires after rearm", err_code, 16'h0010);
    clear();
    drv(0, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    drv(0, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    eq("R12 token rearm restarts", err_code, 16'h0000);
    drv(1, 1, 0, 0, 0);
    eq("R12 token expires after rearm", err_code, 16'h0030);
  endtask

  task automatic t_concurrent();
    clear();
    drv(0, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 0, 0, 0);
    eq("R5 R8 both pending", err_code, 16'h0000);
    drv(1, 1, 0, 0, 0);
    eq("R5 R8 same-cycle expiry", err_code, 16'h0030);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    card_ce = 0; dat0 = 1; blk_sent = 0; rd_wait = 0; err_clr = 0;
    tmo_limit = 16'd4;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_good();
    t_bad_status();
    t_end_bit();
    t_tok_timeout();
    t_busy_timeout();
    t_read();
    t_ce_gaps();
    t_clear();
    t_rearm();
    t_concurrent();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule